// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block divides a fast input clock by a programmable integer ratio and emits one single-cycle pulse per division period. It is built in the pulse-swallow arrangement: a prescaler that divides by either 32 or 33, a 5-bit swallow counter that decides how many of the prescaler cycles are long, and a main counter that counts prescaler cycles. With a main value M and a swallow value A, one output period spans exactly 32·M + A input cycles. The pulse feeds the feedback input of a phase comparator.

The ratio is taken from a divide word. Its low five bits are the swallow value and the bits above them are the main value. A width-select input chooses between a narrow main field of 11 bits (a 16-bit ratio) and a wide one of 13 bits (an 18-bit ratio). The word and the width select are sampled only when the counters reload, so a change takes effect at a period boundary. Main values below 33 are raised to 33. This keeps the swallow count at or below the main count, so every ratio from 1056 up to the top of the selected range is reachable without gaps. The prescaler is modelled as synchronous logic on the same clock as the counters.

Top module: `psd_divider`

## Requirements
- R1: Each prescaler cycle lasts 33 input cycles while the swallow count is nonzero and 32 input cycles once it is zero. The prescaler position never exceeds 32.
- R2: With a main value M of at least 33 and a swallow value A, the distance between consecutive rising edges of `div_pulse` is exactly 32·M + A clock cycles.
- R3: The swallow value is `div_word[4:0]`. With `narrow_sel` = 1 the main value is `div_word[15:5]` and `div_word[17:16]` have no effect. With `narrow_sel` = 0 the main value is `div_word[17:5]`.
- R4: A decoded main value below 33 is replaced by 33. The period is then 1056 + A. Every reload leaves the main count at 33 or more.
- R5: `div_pulse` is high for exactly one clock cycle per period.
- R6: `div_word` and `narrow_sel` are sampled only at the reload that coincides with the end of a period. A change in the middle of a period leaves that period's length unchanged and applies from the next period.
- R7: While `rst_n` is low, `div_pulse` is low. After release, the first rising edge with `rst_n` high loads the counters. `div_pulse` is then first high after rising edge N+1, where N is the programmed ratio.
- R8: While the swallow count is nonzero it stays strictly below the remaining main count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| narrow_sel | input | 1 | 1 = 11-bit main field, 0 = 13-bit main field |
| div_word | input | 18 | Divide word: swallow value in bits 4:0, main value above |
| div_pulse | output | 1 | One-cycle pulse at the end of each division period |

## Verification
The hardest case to reach from the ports is a change of ratio in the middle of a period. The word must move after a reload and before the next one, and the shortened remainder of the old period must still be observed. The stimulus first locks onto a pulse, waits a fixed number of cycles, and then rewrites the word. It expects the old ratio minus that offset for the gap that follows, and the new ratio for the gap after that. The clamp corner is reached by drawing main values below 33, both directly and within the random settings. In the narrow mode, garbage is placed in the two top word bits to show they are ignored.

// File: rtl/psd_pkg.sv
package psd_pkg;
    // Default field widths of the divider
    localparam int PSD_SW_W     = 5;
    localparam int PSD_NARROW_W = 11;
    localparam int PSD_WIDE_W   = 13;

    // Smallest main count that keeps swallow <= main for any swallow value
    function automatic int psd_min_main(input int sw_w);
        return (1 << sw_w) + 1;
    endfunction
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
    parameter int SW_W = psd_pkg::PSD_SW_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic swallow_on,
    output logic tick
);
    localparam int BASE = 1 << SW_W;
    localparam int PC_W = SW_W + 1;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [PC_W-1:0] last_pos;

    always_comb begin
        st_d     = st_q;
        last_pos = swallow_on ? PC_W'(BASE) : PC_W'(BASE - 1);
        tick     = (st_q.pc == last_pos);
        if (load || tick) begin
            st_d.pc = '0;
        end else begin
            st_d.pc = st_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: position bounded by the long modulus
    p_pc_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pc <= PC_W'(BASE));

    // R1: the extra 33rd position only occurs while swallowing
    p_long_only_swallow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pc == PC_W'(BASE)) |-> swallow_on);
endmodule

// File: rtl/psd_swallow.sv
module psd_swallow #(
    parameter int SW_W = psd_pkg::PSD_SW_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SW_W-1:0] load_val,
    input  logic            tick,
    output logic            active,
    output logic [SW_W-1:0] count
);
    typedef struct packed {
        logic [SW_W-1:0] sw;
    } sw_st_t;

    sw_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        active = (st_q.sw != '0);
        count  = st_q.sw;
        if (load) begin
            st_d.sw = load_val;
        end else if (tick && active) begin
            st_d.sw = st_q.sw - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/psd_main.sv
module psd_main #(
    parameter int SW_W     = psd_pkg::PSD_SW_W,
    parameter int NARROW_W = psd_pkg::PSD_NARROW_W,
    parameter int WIDE_W   = psd_pkg::PSD_WIDE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow_sel,
    input  logic [WIDE_W-1:0] main_bits,
    input  logic              load,
    input  logic              tick,
    output logic              last,
    output logic              idle,
    output logic [WIDE_W-1:0] count
);
    localparam int MIN_MAIN = psd_pkg::psd_min_main(SW_W);

    typedef struct packed {
        logic [WIDE_W-1:0] mc;
    } mc_st_t;

    mc_st_t st_d, st_q;
    logic [WIDE_W-1:0] raw_main;
    logic [WIDE_W-1:0] load_main;

    // Field decode: bits beyond the narrow field count only in wide mode
    for (genvar gi = 0; gi < WIDE_W; gi++) begin : g_field
        if (gi < NARROW_W) begin : g_low
            assign raw_main[gi] = main_bits[gi];
        end else begin : g_high
            assign raw_main[gi] = main_bits[gi] & ~narrow_sel;
        end
    end

    always_comb begin
        st_d      = st_q;
        load_main = (raw_main < WIDE_W'(MIN_MAIN)) ? WIDE_W'(MIN_MAIN) : raw_main;
        last      = (st_q.mc == WIDE_W'(1));
        idle      = (st_q.mc == '0);
        count     = st_q.mc;
        if (load) begin
            st_d.mc = load_main;
        end else if (tick) begin
            st_d.mc = st_q.mc - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/psd_divider.sv
module psd_divider #(
    parameter  int SW_W     = psd_pkg::PSD_SW_W,
    parameter  int NARROW_W = psd_pkg::PSD_NARROW_W,
    parameter  int WIDE_W   = psd_pkg::PSD_WIDE_W,
    localparam int WORD_W   = SW_W + WIDE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow_sel,
    input  logic [WORD_W-1:0] div_word,
    output logic              div_pulse
);
    localparam int MIN_MAIN = psd_pkg::psd_min_main(SW_W);

    typedef struct packed {
        logic pulse;
    } top_st_t;

    top_st_t st_d, st_q;

    logic              pre_tick;
    logic              sw_active;
    logic [SW_W-1:0]   sw_cnt;
    logic              mc_last;
    logic              mc_idle;
    logic [WIDE_W-1:0] mc_cnt;
    logic              reload;
    logic              period_end;

    assign period_end = pre_tick & mc_last;
    assign reload     = mc_idle | period_end;

    psd_prescaler #(.SW_W(SW_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (reload),
        .swallow_on (sw_active),
        .tick       (pre_tick)
    );

    psd_swallow #(.SW_W(SW_W)) u_sw (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (div_word[SW_W-1:0]),
        .tick     (pre_tick),
        .active   (sw_active),
        .count    (sw_cnt)
    );

    psd_main #(.SW_W(SW_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_main (
        .clk        (clk),
        .rst_n      (rst_n),
        .narrow_sel (narrow_sel),
        .main_bits  (div_word[WORD_W-1:SW_W]),
        .load       (reload),
        .tick       (pre_tick),
        .last       (mc_last),
        .idle       (mc_idle),
        .count      (mc_cnt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = period_end;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_pulse = st_q.pulse;

    // R5: output pulse lasts a single cycle
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    // R4: the reload that produced a pulse left a main count at or above the floor
    p_reload_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> (mc_cnt >= WIDE_W'(MIN_MAIN)));

    // R8: swallowing always finishes before the main count runs out
    p_swallow_under_main_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_active |-> (mc_cnt > {{(WIDE_W-SW_W){1'b0}}, sw_cnt}));
endmodule

// File: tb/tb_psd_divider.sv
module tb_psd_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        narrow_sel = 1'b1;
    logic [17:0] div_word = '0;
    logic        div_pulse;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    psd_divider dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .narrow_sel (narrow_sel),
        .div_word   (div_word),
        .div_pulse  (div_pulse)
    );

    function automatic int exp_ratio(input logic [17:0] w, input logic s);
        int m;
        m = s ? int'(w[15:5]) : int'(w[17:5]);
        if (m < 33) m = 33;
        return 32 * m + int'(w[4:0]);
    endfunction

    function automatic logic [17:0] mk_word(input int hi2, input int m, input int a);
        logic [17:0] w;
        w = {2'(hi2), 11'(m), 5'(a)};
        return w;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic gap(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_pulse && n < 300000);
    endtask

    task automatic run_setting(input string tag, input logic [17:0] w, input logic s);
        int n;
        div_word   = w;
        narrow_sel = s;
        gap(n);
        gap(n);
        chk(tag, n, exp_ratio(w, s));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 190000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic [17:0] w1, w2;
        void'($urandom(32'd20240611));

        // R7: reset holds the output low
        div_word   = mk_word(0, 40, 7);
        narrow_sel = 1'b1;
        repeat (5) @(negedge clk);
        chk("R7 pulse low in reset", int'(div_pulse), 0);
        rst_n = 1'b1;
        gap(n);
        chk("R7 first pulse latency", n, exp_ratio(div_word, 1'b1) + 1);
        @(negedge clk);
        chk("R5 pulse one cycle wide", int'(div_pulse), 0);
        gap(n);
        chk("R2 period M=40 A=7", n + 1, 1287);

        // R4: clamp of small main values
        run_setting("R4 M=0 A=0", mk_word(0, 0, 0), 1'b1);
        run_setting("R4 M=5 A=31", mk_word(0, 5, 31), 1'b1);
        run_setting("R4 M=32 A=3", mk_word(0, 32, 3), 1'b1);
        run_setting("R2 M=33 A=31 boundary", mk_word(0, 33, 31), 1'b1);
        // R1: no long prescaler cycles with zero swallow
        run_setting("R1 M=34 A=0", mk_word(0, 34, 0), 1'b1);
        // R3: top bits ignored in narrow mode
        run_setting("R3 narrow ignores top bits", mk_word(3, 50, 9), 1'b1);
        run_setting("R3 wide mode small word", mk_word(0, 50, 9), 1'b0);

        // R6: mid-period change
        w1 = mk_word(0, 45, 12);
        w2 = mk_word(0, 38, 20);
        run_setting("R6 lock old ratio", w1, 1'b1);
        repeat (10) @(negedge clk);
        div_word = w2;
        gap(n);
        chk("R6 old period kept", n + 10, exp_ratio(w1, 1'b1));
        gap(n);
        chk("R6 new ratio applied", n, exp_ratio(w2, 1'b1));

        // R2/R3/R4: random settings in both modes
        for (int i = 0; i < 10; i++) begin
            logic s;
            int m, a, hi;
            s  = 1'($urandom_range(0, 1));
            m  = $urandom_range(0, 110);
            a  = $urandom_range(0, 31);
            hi = s ? $urandom_range(0, 3) : 0;
            run_setting(s ? "R2 R3 random narrow" : "R2 R3 random wide",
                        mk_word(hi, m, a), s);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule